// File: doc/BRIEF.md
# Banked Digital Input Capture Port

This block samples two 16-bit digital input ports at the same moment and keeps the captured words for a processor to read over a simple register bus. The capture moment comes from one of two sources. The first is an internal tick at 1 MHz, derived from the system clock. The second is the rising edge of an external trigger input, which is synchronized into the system clock domain before use. Both ports are read through a single data address, and a bank-select bit in the control register decides which port's word comes back.

Every capture sets a data-ready marker. The marker can drive a level interrupt, but only while the external trigger is the selected source and the interrupt enable is set. With the internal tick selected, an interrupt would fire every microsecond, so the block masks it. Changing the capture source clears the marker. A short settling window follows the change, and any capture that falls inside it is dropped.

Top module: `banked_capture_port`

## Requirements
- R1: After reset, a control read (address 0) returns 0x0000, a data read (address 2) returns 0x0000 and `irq` is low. The external trigger is the selected source.
- R2: With the external source selected, a rising edge on `ext_trig` captures `port_lo` and `port_hi` together. The capture happens at the third rising system clock edge after the input changes (two synchronizer flops plus one edge flop).
- R3: Control bit 4 is the bank select. At 0 a data read returns the lower port word, and at 1 it returns the upper port word. Data bit n carries input bit n of the chosen port.
- R4: With control bit 1 set, the internal source is selected and a capture happens once every SYS_CLK_HZ/TICK_HZ system clocks (100 by default).
- R5: Each capture sets the data-ready marker, which reads back as control bit 0. A data read clears it unless a capture happens in the same cycle.
- R6: `irq` is high exactly when the marker is set, control bit 2 (interrupt enable) is 1 and the external source is selected. With bit 2 at 0, no capture ever raises `irq`.
- R7: While the internal source is selected, `irq` stays low even with the interrupt enable set and the marker set.
- R8: A control write that changes bit 1 clears the marker at that clock edge, even if a capture is due in the same cycle.
- R9: For SWITCH_CYCLES system clocks after a source change (2 by default), capture strobes are discarded. They neither change the stored words nor set the marker.
- R10: Writes to the data address change neither the stored words nor the marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 4 | Word address: 0 control, 2 channel data |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_rd` is high |
| port_lo | input | 16 | Lower input port (bank 0) |
| port_hi | input | 16 | Upper input port (bank 1) |
| ext_trig | input | 1 | External capture trigger, asynchronous |
| irq | output | 1 | Level data-available interrupt |

## Verification
A marker stuck in the wrong state shows at once, either on control bit 0 or on `irq` in the cycle after a capture, a data read or a source change. The switching window is the subtle state. If its counter is off by one, an external edge timed to land on the last cycle of the window is captured when it should be dropped, and the next data read then returns the new port word instead of the word captured before the switch. A divider fault moves the first internal capture by whole cycles, and a wrong bank or port wiring shows on the first data read.

// File: rtl/cap_pkg.sv
// Package: shared constants for the banked capture port.
// Assumes a bus data width of at least 5 bits so every control field fits.
package cap_pkg;
    localparam int ADDR_W       = 4;
    localparam int CTRL_ADDR    = 0;
    localparam int DATA_ADDR    = 2;
    localparam int READY_BIT    = 0;
    localparam int INT_SEL_BIT  = 1;
    localparam int IRQ_EN_BIT   = 2;
    localparam int BANK_BIT     = 4;

    typedef struct packed {
        logic bank;
        logic irq_en;
    } ctrl_t;
endpackage

// File: rtl/cap_tick_gen.sv
// Module: internal capture tick generator.
// Produces a one-cycle pulse every SYS_CLK_HZ/TICK_HZ clocks while enabled.
// Assumes the ratio is an integer of at least 2. The count restarts from 0
// whenever the enable drops.
module cap_tick_gen #(
    parameter int SYS_CLK_HZ = 100_000_000,
    parameter int TICK_HZ    = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    output logic tick
);
    localparam int DIV = SYS_CLK_HZ / TICK_HZ;
    localparam int CW  = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_q;

    // Divide the system clock down to the tick rate.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(DIV - 1)) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = enable && (cnt_q == CW'(DIV - 1));

    // R4: a tick never lasts more than one cycle.
    p_tick_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/cap_ext_sync.sv
// Module: external trigger synchronizer and rising-edge detector.
// Assumes ext_in is asynchronous to clk and stays high for at least one
// clock period. rise pulses for one cycle, STAGES+1 edges after the input
// goes high.
module cap_ext_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Move the trigger into the clock domain through a flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q[0] <= ext_in;
            for (int i = 1; i < STAGES; i++) begin
                sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= 1'b0;
        end else begin
            last_q <= sync_q[STAGES-1];
        end
    end

    assign rise = sync_q[STAGES-1] && !last_q;

    // R2: each rising edge gives exactly one strobe cycle.
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/cap_src_ctrl.sv
// Module: capture source selection and switching window.
// Owns the source-select flop. On a change it clears the marker and opens
// a window of SWITCH_CYCLES clocks in which capture strobes are dropped.
// Assumes sel_load comes from a single-cycle bus write.
module cap_src_ctrl #(
    parameter int SWITCH_CYCLES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_load,
    input  logic sel_din,
    input  logic tick,
    input  logic ext_rise,
    output logic int_sel,
    output logic change,
    output logic window,
    output logic strobe
);
    localparam int WW = $clog2(SWITCH_CYCLES + 1);

    logic          sel_q;
    logic [WW-1:0] win_q;
    logic          raw_strobe;

    assign change = sel_load && (sel_din != sel_q);

    // Register the selected capture source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else if (sel_load) begin
            sel_q <= sel_din;
        end
    end

    // Count down the settling window after a source change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (change) begin
            win_q <= WW'(SWITCH_CYCLES);
        end else if (win_q != '0) begin
            win_q <= win_q - 1'b1;
        end
    end

    // Pick the live strobe and drop it during a switch.
    always_comb begin
        raw_strobe = sel_q ? tick : ext_rise;
        strobe     = raw_strobe && !change && (win_q == '0);
    end

    assign int_sel = sel_q;
    assign window  = (win_q != '0);

    // R9: no strobe while the window is open.
    p_no_strobe_in_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
        window |-> !strobe);
endmodule

// File: rtl/cap_word_latch.sv
// Module: captured word storage and data-ready marker.
// Latches every port word on a strobe. The marker is cleared by a source
// change (highest priority), set by a strobe and cleared by a data read.
module cap_word_latch #(
    parameter int DATA_W    = 16,
    parameter int NUM_PORTS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        strobe,
    input  logic                        clr,
    input  logic                        rd_ack,
    input  logic [NUM_PORTS*DATA_W-1:0] ports_in,
    output logic [NUM_PORTS*DATA_W-1:0] words,
    output logic                        ready
);
    logic ready_q;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        // Hold the most recent captured word of this port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[p*DATA_W +: DATA_W] <= '0;
            end else if (strobe) begin
                words[p*DATA_W +: DATA_W] <= ports_in[p*DATA_W +: DATA_W];
            end
        end
    end

    // Track whether an unread capture is waiting.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ready_q <= 1'b0;
        end else if (strobe) begin
            ready_q <= 1'b1;
        end else if (rd_ack) begin
            ready_q <= 1'b0;
        end
    end

    assign ready = ready_q;

    // R5: a strobe always leaves the marker set unless a clear came with it.
    p_strobe_sets_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !clr) |=> ready);
endmodule

// File: rtl/banked_capture_port.sv
// Module: banked digital input capture port (top).
// Decodes the register bus, holds the control fields, muxes the banked
// read and drives the level interrupt. Reads are combinational while
// bus_rd is high. Side effects of an access take place at the clock edge
// that ends the access.
module banked_capture_port
    import cap_pkg::*;
#(
    parameter int DATA_W        = 16,
    parameter int SYS_CLK_HZ    = 100_000_000,
    parameter int TICK_HZ       = 1_000_000,
    parameter int SWITCH_CYCLES = 2,
    parameter int SYNC_STAGES   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] port_lo,
    input  logic [DATA_W-1:0] port_hi,
    input  logic              ext_trig,
    output logic              irq
);
    localparam int NUM_PORTS = 2;

    ctrl_t                       ctrl_q;
    logic                        sel_ctrl, sel_data;
    logic                        wr_ctrl, wr_data, rd_data;
    logic                        tick, ext_rise;
    logic                        int_sel, src_change, window, strobe;
    logic                        ready;
    logic [NUM_PORTS*DATA_W-1:0] words;
    logic [DATA_W-1:0]           lo_word, hi_word;
    logic                        unused_wdata;

    assign sel_ctrl = (bus_addr == ADDR_W'(CTRL_ADDR));
    assign sel_data = (bus_addr == ADDR_W'(DATA_ADDR));
    assign wr_ctrl  = bus_wr && sel_ctrl;
    assign wr_data  = bus_wr && sel_data;
    assign rd_data  = bus_rd && sel_data;

    assign unused_wdata = ^{bus_wdata[DATA_W-1:BANK_BIT+1], bus_wdata[BANK_BIT-1:IRQ_EN_BIT+1],
                            bus_wdata[READY_BIT]};

    // Store the bank select and interrupt enable fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.bank   <= bus_wdata[BANK_BIT];
            ctrl_q.irq_en <= bus_wdata[IRQ_EN_BIT];
        end
    end

    cap_tick_gen #(
        .SYS_CLK_HZ (SYS_CLK_HZ),
        .TICK_HZ    (TICK_HZ)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (int_sel && !window),
        .tick   (tick)
    );

    cap_ext_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_trig),
        .rise   (ext_rise)
    );

    cap_src_ctrl #(
        .SWITCH_CYCLES (SWITCH_CYCLES)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_load (wr_ctrl),
        .sel_din  (bus_wdata[INT_SEL_BIT]),
        .tick     (tick),
        .ext_rise (ext_rise),
        .int_sel  (int_sel),
        .change   (src_change),
        .window   (window),
        .strobe   (strobe)
    );

    cap_word_latch #(
        .DATA_W    (DATA_W),
        .NUM_PORTS (NUM_PORTS)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .clr      (src_change),
        .rd_ack   (rd_data),
        .ports_in ({port_hi, port_lo}),
        .words    (words),
        .ready    (ready)
    );

    assign lo_word = words[0 +: DATA_W];
    assign hi_word = words[DATA_W +: DATA_W];

    // Drive read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (sel_ctrl) begin
                bus_rdata[READY_BIT]   = ready;
                bus_rdata[INT_SEL_BIT] = int_sel;
                bus_rdata[IRQ_EN_BIT]  = ctrl_q.irq_en;
                bus_rdata[BANK_BIT]    = ctrl_q.bank;
            end else if (sel_data) begin
                bus_rdata = ctrl_q.bank ? hi_word : lo_word;
            end
        end
    end

    // Raise the interrupt only for external captures with the enable set.
    assign irq = ready && ctrl_q.irq_en && !int_sel;

    // R8: a source change leaves the marker clear at the next edge.
    p_switch_clears_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        src_change |=> !ready);

    // R9: stored words hold across the switching window.
    p_window_holds_words_r9: assert property (@(posedge clk) disable iff (!rst_n)
        window |=> ($stable(lo_word) && $stable(hi_word)));

    // R10: a write to the data address changes nothing.
    p_data_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data && !strobe && !src_change && !rd_data)
        |=> ($stable(lo_word) && $stable(hi_word) && $stable(ready)));

    // R5: a data read without a capture clears the marker.
    p_read_clears_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data && !strobe) |=> !ready);
endmodule

// File: tb/banked_capture_port_test.sv
module banked_capture_port_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] port_lo = '0;
    logic [15:0] port_hi = '0;
    logic        ext_trig = 1'b0;
    logic        irq;
    logic        chk_irq = 1'b0;
    logic        done = 1'b0;
    int          compared = 0;
    int          mismatched = 0;

    typedef struct {
        bit          is_irq;
        logic [15:0] value;
        string       tag;
    } item_t;
    item_t exp_q[$];

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_DATA = 4'd2;

    always #5 clk = ~clk;

    banked_capture_port uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .port_lo   (port_lo),
        .port_hi   (port_hi),
        .ext_trig  (ext_trig),
        .irq       (irq)
    );

    // Monitor: pop the expected item and compare it mid low phase.
    always begin
        @(negedge clk);
        #2;
        if (bus_rd || chk_irq) begin
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL monitor: unexpected sample (actual %h, expected none)", bus_rdata);
            end else begin
                item_t it;
                logic [15:0] act;
                it = exp_q.pop_front();
                act = it.is_irq ? {15'b0, irq} : bus_rdata;
                compared++;
                if (act !== it.value)
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.value);
                if (act !== it.value) mismatched++;
            end
        end
    end

    task automatic rd(input logic [3:0] a, input logic [15:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_rd = 1'b1;
        exp_q.push_back('{1'b0, e, tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic chk(input logic e, input string tag);
        @(negedge clk);
        chk_irq = 1'b1;
        exp_q.push_back('{1'b1, {15'b0, e}, tag});
        @(negedge clk);
        chk_irq = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic ext_pulse();
        @(negedge clk);
        ext_trig = 1'b1;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_CTRL, 16'h0000, "R1 ctrl after reset");
        rd(A_DATA, 16'h0000, "R1 data after reset");
        chk(1'b0, "R1 irq after reset");

        // R2, R3, R5: external capture, bank select, marker
        port_lo = 16'hA5A5;
        port_hi = 16'h3C3C;
        ext_pulse();
        rd(A_CTRL, 16'h0001, "R5 marker set by capture");
        rd(A_DATA, 16'hA5A5, "R2 R3 bank0 returns lower port");
        rd(A_CTRL, 16'h0000, "R5 marker cleared by data read");
        wr(A_CTRL, 16'h0010);
        rd(A_DATA, 16'h3C3C, "R3 bank1 returns upper port");

        // R10: write to data address ignored
        port_lo = 16'h0001;
        wr(A_DATA, 16'hFFFF);
        rd(A_DATA, 16'h3C3C, "R10 data write no effect on word");
        rd(A_CTRL, 16'h0010, "R10 data write no effect on marker");

        // R6: interrupt with external source
        wr(A_CTRL, 16'h0004);
        chk(1'b0, "R6 irq low before capture");
        port_lo = 16'h1234;
        ext_pulse();
        chk(1'b1, "R6 irq after external capture");
        rd(A_CTRL, 16'h0005, "R6 ctrl with marker and enable");
        rd(A_DATA, 16'h1234, "R6 data of capture");
        chk(1'b0, "R6 irq drops after data read");
        wr(A_CTRL, 16'h0000);
        ext_pulse();
        chk(1'b0, "R6 no irq with enable off");
        rd(A_CTRL, 16'h0001, "R6 marker set with enable off");
        rd(A_DATA, 16'h1234, "R6 clear marker");

        // R4, R7: internal source
        port_lo = 16'hBEEF;
        wr(A_CTRL, 16'h0006);
        repeat (120) @(negedge clk);
        chk(1'b0, "R7 irq masked with internal source");
        rd(A_CTRL, 16'h0007, "R4 internal tick sets marker");
        rd(A_DATA, 16'hBEEF, "R4 internal tick captured port");
        repeat (120) @(negedge clk);
        rd(A_CTRL, 16'h0007, "R4 marker set again");

        // R8: source change clears marker
        wr(A_CTRL, 16'h0004);
        rd(A_CTRL, 16'h0004, "R8 marker cleared by source change");
        chk(1'b0, "R8 irq low after switch");

        // R9: capture inside the window is lost
        wr(A_CTRL, 16'h0002);
        repeat (120) @(negedge clk);
        @(negedge clk);
        bus_addr = A_CTRL;
        bus_wdata = 16'h0000;
        bus_wr = 1'b1;
        port_lo = 16'h7777;
        ext_trig = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        repeat (3) @(negedge clk);
        ext_trig = 1'b0;
        repeat (8) @(negedge clk);
        rd(A_CTRL, 16'h0000, "R9 edge in window sets no marker");
        rd(A_DATA, 16'hBEEF, "R9 edge in window keeps old word");
        ext_pulse();
        rd(A_DATA, 16'h7777, "R9 edge after window captured");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run is a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule